// File: doc/BRIEF.md
# TDM Frame-Sync Serial Transmitter

This block turns a stream of parallel channel words into a time-division multiplexed serial frame. It drives its own serial clock, an active-low frame-sync strobe and a serial data line towards a downstream receiver. Words arrive over a valid/ready handshake and are held in a local buffer that has room for one full frame. A frame is launched only when every word it will carry is already in that buffer. Because of this, a stall on the input side can delay a frame but can never cut one short or pad it. The word that follows frame sync is therefore always channel 0.

The serial clock runs at half the system clock. It toggles only while a frame is on the line and otherwise rests low. Each frame has three parts. Frame sync is held low for the first two serial-clock periods. One serial-clock period of start delay follows with the data line low. Then come the channel words, most significant bit first, with one bit per serial-clock period. The number of channels per frame is taken from a configuration input coded as N-1 and is captured when a frame starts. If the next frame is already complete when the last bit of a frame ends, the next frame sync follows without a gap.

Top module: `tdm_tx`

## Requirements
- R1: After reset, ser_clk is 0, ser_fs_n is 1, ser_data is 0, busy is 0 and in_ready is 1.
- R2: While a frame is on the line, ser_clk is high for one system-clock cycle and low for the next, so its rising edges are exactly two cycles apart. While no frame is on the line, ser_clk stays low.
- R3: While fewer than N words are held, no frame starts: ser_fs_n stays 1, ser_clk stays 0, busy stays 0 and ser_data stays 0.
- R4: ser_fs_n is 0 for the first two serial-clock rising edges of each frame, which is exactly four system-clock cycles, and is 1 at every other rising edge.
- R5: At the third rising edge of a frame, ser_fs_n is 1 and ser_data is 0 (start delay). The first data bit appears at the fourth rising edge.
- R6: Each word is W bits long (default 16) and is sent most significant bit first, one bit per serial-clock period. ser_data and ser_fs_n change only on the cycle in which ser_clk rises, or on the cycle in which the line returns to idle.
- R7: Words are sent in the order they were accepted. Each frame carries exactly N words, and the first word after frame sync is always the oldest word held.
- R8: N is cfg_nch_m1 + 1 and may be any value from 1 to CH_MAX (default 4). It is captured when frame sync falls, and the frame start condition uses the value present at that moment.
- R9: If N words are held when the last bit period of a frame ends, the next frame sync falls on the very next serial-clock rising edge, so consecutive frame starts are 2*(3+N*W) cycles apart.
- R10: busy is 1 from the cycle in which frame sync falls until the end of the last bit period, and 0 otherwise. Frame sync low implies busy.
- R11: The buffer holds CH_MAX words. in_ready is 0 when it is full, and a word is taken on any cycle with in_valid and in_ready both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_nch_m1 | input | $clog2(CH_MAX) | Channels per frame minus one |
| in_valid | input | 1 | Input word valid |
| in_data | input | WORD_W | Input channel word |
| in_ready | output | 1 | Buffer has room for a word |
| ser_clk | output | 1 | Gated serial clock, half rate |
| ser_fs_n | output | 1 | Active-low frame sync |
| ser_data | output | 1 | Serial data, MSB first |
| busy | output | 1 | Frame in progress |

## Verification
The checker watches the line discipline on every cycle. It checks that the clock stays low when the block is idle and that the clock high phase lasts one cycle. It checks that the frame-sync pulse is exactly four cycles long and that data and frame sync move only with a clock rise. It also checks that frame sync implies busy, that a frame starts only with enough words buffered, and that a full buffer drops in_ready. Word content and ordering, the start delay slot, channel alignment after random stalls, the N-1 coding across channel counts, and back-to-back frame spacing depend on the history of accepted words. The bench shows these by decoding the serial line against its own queue of accepted words.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DLY  = 2'd2,
    ST_DATA = 2'd3
  } tx_state_e;
endpackage

// File: rtl/tdm_tx_buf.sv
module tdm_tx_buf #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic [WORD_W-1:0]                push_data,
  input  logic                             pop,
  output logic [WORD_W-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]       count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_d  = push ? wrap_inc(wr_q) : wr_q;
    rd_d  = pop  ? wrap_inc(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + CW'(1);
    else if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic wen;
    assign wen = push && (wr_q == AW'(e));
    always_ff @(posedge clk) begin
      if (wen) mem_q[e] <= push_data;
    end
  end

  assign head  = mem_q[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
  import tdm_tx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CH_MAX = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [((CH_MAX>1)?$clog2(CH_MAX):1)-1:0] cfg_nch_m1,
  input  logic [$clog2(CH_MAX+1)-1:0]            buf_count,
  input  logic [WORD_W-1:0]                      buf_head,
  output logic                                   buf_pop,
  output logic                                   ser_clk,
  output logic                                   ser_fs_n,
  output logic                                   ser_data,
  output logic                                   busy
);
  localparam int NW = (CH_MAX > 1) ? $clog2(CH_MAX) : 1;
  localparam int CW = $clog2(CH_MAX+1);
  localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  tx_state_e         state_q, state_d;
  logic              ph_q, ph_d;
  logic              sc_q, sc_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [NW-1:0]     ch_q, ch_d, nf_q, nf_d, nch_eff;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              clk_q, clk_d, fs_q, fs_d, dat_q, dat_d, busy_q, busy_d;
  logic [CW-1:0]     need;
  logic              frame_ready, go_sync, load, adv;

  assign nch_eff     = (cfg_nch_m1 > NW'(CH_MAX-1)) ? NW'(CH_MAX-1) : cfg_nch_m1;
  assign need        = CW'(nch_eff) + CW'(1);
  assign frame_ready = (buf_count >= need);
  assign adv         = (state_q != ST_IDLE) || frame_ready;

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    sc_d    = sc_q;
    bit_d   = bit_q;
    ch_d    = ch_q;
    nf_d    = nf_q;
    sh_d    = sh_q;
    clk_d   = 1'b0;
    fs_d    = fs_q;
    dat_d   = dat_q;
    go_sync = 1'b0;
    load    = 1'b0;
    if (state_q == ST_IDLE) begin
      go_sync = frame_ready;
    end else if (!ph_q) begin
      ph_d = 1'b1;
    end else begin
      ph_d  = 1'b0;
      clk_d = 1'b1;
      case (state_q)
        ST_SYNC: begin
          if (!sc_q) sc_d = 1'b1;
          else begin
            state_d = ST_DLY;
            fs_d    = 1'b1;
          end
        end
        ST_DLY: begin
          state_d = ST_DATA;
          bit_d   = '0;
          ch_d    = '0;
          load    = 1'b1;
        end
        ST_DATA: begin
          if (bit_q != BW'(WORD_W-1)) begin
            bit_d = bit_q + BW'(1);
            dat_d = sh_q[WORD_W-1];
            sh_d  = sh_q << 1;
          end else if (ch_q != nf_q) begin
            ch_d  = ch_q + NW'(1);
            bit_d = '0;
            load  = 1'b1;
          end else if (frame_ready) begin
            go_sync = 1'b1;
          end else begin
            state_d = ST_IDLE;
            clk_d   = 1'b0;
            dat_d   = 1'b0;
          end
        end
        default: ;
      endcase
    end
    if (load) begin
      dat_d = buf_head[WORD_W-1];
      sh_d  = buf_head << 1;
    end
    if (go_sync) begin
      state_d = ST_SYNC;
      ph_d    = 1'b0;
      sc_d    = 1'b0;
      nf_d    = nch_eff;
      clk_d   = 1'b1;
      fs_d    = 1'b0;
      dat_d   = 1'b0;
    end
    busy_d = (state_d != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      sc_q    <= 1'b0;
      bit_q   <= '0;
      ch_q    <= '0;
      nf_q    <= '0;
      sh_q    <= '0;
      clk_q   <= 1'b0;
      fs_q    <= 1'b1;
      dat_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else if (adv) begin
      state_q <= state_d;
      ph_q    <= ph_d;
      sc_q    <= sc_d;
      bit_q   <= bit_d;
      ch_q    <= ch_d;
      nf_q    <= nf_d;
      sh_q    <= sh_d;
      clk_q   <= clk_d;
      fs_q    <= fs_d;
      dat_q   <= dat_d;
      busy_q  <= busy_d;
    end
  end

  assign buf_pop  = load;
  assign ser_clk  = clk_q;
  assign ser_fs_n = fs_q;
  assign ser_data = dat_q;
  assign busy     = busy_q;
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
  parameter int WORD_W = 16,
  parameter int CH_MAX = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [((CH_MAX>1)?$clog2(CH_MAX):1)-1:0] cfg_nch_m1,
  input  logic                                     in_valid,
  input  logic [WORD_W-1:0]                        in_data,
  output logic                                     in_ready,
  output logic                                     ser_clk,
  output logic                                     ser_fs_n,
  output logic                                     ser_data,
  output logic                                     busy
);
  localparam int CW = $clog2(CH_MAX+1);

  logic              push, pop;
  logic [WORD_W-1:0] head;
  logic [CW-1:0]     buf_cnt;

  assign in_ready = (buf_cnt != CW'(CH_MAX));
  assign push     = in_valid && in_ready;

  tdm_tx_buf #(.WORD_W(WORD_W), .DEPTH(CH_MAX)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (in_data),
    .pop       (pop),
    .head      (head),
    .count     (buf_cnt)
  );

  tdm_tx_framer #(.WORD_W(WORD_W), .CH_MAX(CH_MAX)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_nch_m1 (cfg_nch_m1),
    .buf_count  (buf_cnt),
    .buf_head   (head),
    .buf_pop    (pop),
    .ser_clk    (ser_clk),
    .ser_fs_n   (ser_fs_n),
    .ser_data   (ser_data),
    .busy       (busy)
  );
endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk #(
  parameter int CH_MAX = 4
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic [((CH_MAX>1)?$clog2(CH_MAX):1)-1:0] cfg_nch_m1,
  input logic                                     in_ready,
  input logic [$clog2(CH_MAX+1)-1:0]              buf_cnt,
  input logic                                     ser_clk,
  input logic                                     ser_fs_n,
  input logic                                     ser_data,
  input logic                                     busy
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_clk);

  p_half_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |=> !ser_clk);

  p_start_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_fs_n) |-> ((int'($past(buf_cnt)) > int'($past(cfg_nch_m1))) ||
                         (int'($past(buf_cnt)) == CH_MAX)));

  p_fs_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_fs_n) |=> !ser_fs_n ##1 !ser_fs_n ##1 !ser_fs_n ##1 ser_fs_n);

  p_data_moves_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data) |-> (ser_clk || !busy));

  p_fs_moves_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_fs_n) |-> ser_clk);

  p_fs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_fs_n |-> busy);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(buf_cnt) == CH_MAX) |-> !in_ready);
endmodule

bind tdm_tx tdm_tx_chk #(.CH_MAX(CH_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_nch_m1 (cfg_nch_m1),
  .in_ready   (in_ready),
  .buf_cnt    (buf_cnt),
  .ser_clk    (ser_clk),
  .ser_fs_n   (ser_fs_n),
  .ser_data   (ser_data),
  .busy       (busy)
);

// File: tb/tdm_tx_bench.sv
module tdm_tx_bench;
  localparam int W  = 16;
  localparam int CH = 4;

  logic         clk;
  logic         rst_n;
  logic [1:0]   cfg_nch_m1;
  logic         in_valid;
  logic [W-1:0] in_data;
  logic         in_ready, ser_clk, ser_fs_n, ser_data, busy;

  tdm_tx #(.WORD_W(W), .CH_MAX(CH)) u_tdm_tx (
    .clk(clk), .rst_n(rst_n), .cfg_nch_m1(cfg_nch_m1),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .ser_clk(ser_clk), .ser_fs_n(ser_fs_n), .ser_data(ser_data), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  int n_cur = 4;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int frame_cycles(input int n);
    return 2 * (3 + n * W);
  endfunction

  // serial line decoder
  logic         prev_clk;
  int           cyc, last_rise, mpos, fn, bitc, rises, fs_start, prev_fs_start;
  logic [W-1:0] acc;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_clk = 1'b0; cyc = 0; last_rise = 0; mpos = 0; fn = 1; bitc = 0;
      rises = 0; fs_start = 0; prev_fs_start = 0; acc = '0;
    end else begin
      cyc++;
      if (ser_clk && !prev_clk) begin
        rises++;
        chk(busy === 1'b1, "R10", "busy at clock rise", busy, 1);
        if (mpos != 0)
          chk(cyc - last_rise == 2, "R2", "rise spacing", cyc - last_rise, 2);
        last_rise = cyc;
        if (mpos == 0) begin
          chk(ser_fs_n === 1'b0, "R4", "frame sync at first rise", ser_fs_n, 0);
          chk(exp_q.size() >= n_cur, "R3", "words held at frame start", exp_q.size(), n_cur);
          fn = n_cur;
          prev_fs_start = fs_start;
          fs_start = cyc;
        end else if (mpos == 1) begin
          chk(ser_fs_n === 1'b0, "R4", "frame sync at second rise", ser_fs_n, 0);
        end else if (mpos == 2) begin
          chk(ser_fs_n === 1'b1 && ser_data === 1'b0, "R5", "delay slot fs/data",
              {ser_fs_n, ser_data}, 2'b10);
        end else begin
          if (ser_fs_n !== 1'b1) chk(0, "R4", "frame sync in data", ser_fs_n, 1);
          acc = {acc[W-2:0], ser_data};
          bitc++;
          if (bitc == W) begin
            bitc = 0;
            if (exp_q.size() == 0) chk(0, "R7", "word with empty queue", acc, 0);
            else begin
              logic [W-1:0] e;
              e = exp_q.pop_front();
              chk(acc === e, (mpos == 3 + W - 1) ? "R7" : "R6", "word on line", acc, e);
            end
          end
        end
        mpos = (mpos == 3 + fn * W - 1) ? 0 : mpos + 1;
      end
      prev_clk = ser_clk;
    end
  end

  task automatic push(input logic [W-1:0] w);
    bit ok;
    in_valid = 1'b1;
    in_data  = w;
    do begin
      ok = in_ready;
      @(posedge clk);
    end while (!ok);
    exp_q.push_back(w);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string req);
    in_valid = 1'b0;
    while (exp_q.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
    chk(!ser_clk && ser_fs_n && !ser_data, req, "idle line after drain",
        {ser_clk, ser_fs_n, ser_data}, 3'b010);
  endtask

  task automatic set_n(input int n);
    n_cur = n;
    cfg_nch_m1 = 2'(n - 1);
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; set_n(4);
    repeat (3) @(negedge clk);
    chk(!ser_clk && ser_fs_n && !ser_data && !busy && in_ready, "R1", "reset outputs",
        {ser_clk, ser_fs_n, ser_data, busy, in_ready}, 5'b01001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ser_clk && ser_fs_n && !busy, "R1", "after release", {ser_clk, ser_fs_n, busy}, 3'b010);

    // R3: N-1 words never start a frame
    set_n(4);
    for (int i = 0; i < 3; i++) push(16'hFFFF >> i);
    begin
      int r0;
      r0 = rises;
      idle(200);
      chk(rises == r0 && !busy && ser_fs_n, "R3", "no frame with 3 of 4 words", rises - r0, 0);
    end
    push(16'h0505);
    drain("R3");

    // R11: full buffer drops in_ready; R9: back-to-back frames
    for (int i = 0; i < 4; i++) push(16'hA000 + 16'(i));
    chk(in_ready === 1'b0, "R11", "in_ready with full buffer", in_ready, 0);
    for (int i = 0; i < 4; i++) push(16'h5000 + 16'(i));
    drain("R9");
    chk(fs_start - prev_fs_start == frame_cycles(4), "R9", "back-to-back spacing",
        fs_start - prev_fs_start, frame_cycles(4));

    // R8: one-channel and two-channel frames
    set_n(1);
    push(16'h8001);
    push(16'h7FFE);
    drain("R8");
    chk(fs_start - prev_fs_start == frame_cycles(1), "R8", "one-channel frame spacing",
        fs_start - prev_fs_start, frame_cycles(1));
    set_n(2);
    push(16'h1234); push(16'hFEDC);
    drain("R8");

    // constrained random traffic with stalls across channel counts
    foreach (n_cur_list[k]) begin
      set_n(n_cur_list[k]);
      for (int i = 0; i < n_cur_list[k] * 5; i++) begin
        push(16'($urandom));
        if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 60));
      end
      drain("R7");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int n_cur_list[4] = '{4, 3, 1, 2};
endmodule